// File: doc/BRIEF.md
# Real-Time Clock Update Interrupt Controller

This block raises a periodic interrupt each time the timekeeping counter of a real-time clock advances a second or a minute. It receives a one-second tick, a minute tick aligned with the one-second tick, and a 32.768 kHz clock enable, all from the counter chain outside the block. A small register port reaches three byte registers: an extension register holding the event source select, a flag register holding the sticky update flag, and a control register holding the interrupt enable and a counter-hold bit.

On each selected update the block sets the sticky flag. If the enable bit is set, it also asks the pad to pull the active-low, open-drain interrupt line low. The request releases by itself after 256 periods of the 32.768 kHz enable, which is 7.8125 ms. Software can cut the request short by clearing the enable bit. Clearing the flag leaves the request alone. While the hold bit is set, no update events are recognised at all.

Top module: `rtc_upd_irq`

## Requirements
- R1: After reset, the registers at addresses 0xD, 0xE and 0xF all read 0x00 and `irq_drive_low` is 0.
- R2: With bit 5 of register 0xD at 0, each `sec_tick` pulse is an update event. With bit 5 at 1, an event needs `min_tick` high in the same cycle as `sec_tick`, and a `sec_tick` alone is ignored.
- R3: An event sets bit 5 of register 0xE one clock later. The bit stays at 1 until a write to 0xE with bit 5 at 0 clears it.
- R4: A write to 0xE with bit 5 at 1 leaves bit 5 unchanged. An event in the same cycle as a clearing write leaves the bit at 1.
- R5: Clearing bit 5 of 0xE does not release an `irq_drive_low` that is already 1.
- R6: `irq_drive_low` rises one clock after an event only if bit 5 of register 0xF held 1 when the event occurred. With that bit at 0, the output stays 0 but the flag still sets.
- R7: Once raised, `irq_drive_low` stays 1 through 255 cycles with `tick_32k` high and falls one clock after the 256th such cycle.
- R8: An event while `irq_drive_low` is 1 restarts the 256-tick release count.
- R9: A write to 0xF with bit 5 at 0 forces `irq_drive_low` to 0 one clock later, even when an event occurs in the same cycle.
- R10: While bit 0 of register 0xF is 1, `sec_tick` causes no event: the flag does not set and the output does not rise.
- R11: All bits of 0xD and 0xF other than those above, and all bits of 0xE other than bit 5, read back the last value written. Any other address reads 0x00. `rdata` follows `addr` combinationally, and writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| sec_tick | input | 1 | One-cycle pulse on each seconds update |
| min_tick | input | 1 | High together with `sec_tick` when the seconds roll over to 00 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_drive_low | output | 1 | 1 asks the pad to pull the interrupt line low; 0 leaves it high-impedance |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: an event arriving together with a clearing write to the flag, or together with a cancelling write to the enable bit. The bench reaches them by raising `sec_tick` in the same cycle as the write strobe. The release window is also hard to probe at its edges. For that, the bench counts `tick_32k` pulses one at a time and samples the output after the 255th and the 256th pulse. It also re-triggers an event part way through a window to show that the count restarts.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
   localparam int REG_EXT_ADDR  = 13;
   localparam int REG_FLAG_ADDR = 14;
   localparam int REG_CTRL_ADDR = 15;
   localparam int UPD_BIT       = 5;
   localparam int HOLD_BIT      = 0;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_EXT,
      SEL_FLAG,
      SEL_CTRL
   } reg_sel_e;
endpackage

// File: rtl/rtc_upd_regs.sv
module rtc_upd_regs
   import rtc_upd_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ev,
   output logic [DATA_W-1:0] rdata,
   output logic              sel_min,
   output logic              upd_flag,
   output logic              upd_en,
   output logic              hold,
   output logic              cancel
);
   reg_sel_e          sel;
   logic              wr_ext, wr_flag, wr_ctrl;
   logic [DATA_W-1:0] ext_q, flag_q, ctrl_q, flag_nxt;

   always_comb begin
      if (addr == ADDR_W'(REG_EXT_ADDR))       sel = SEL_EXT;
      else if (addr == ADDR_W'(REG_FLAG_ADDR)) sel = SEL_FLAG;
      else if (addr == ADDR_W'(REG_CTRL_ADDR)) sel = SEL_CTRL;
      else                                     sel = SEL_NONE;
   end

   assign wr_ext  = wr_en && (sel == SEL_EXT);
   assign wr_flag = wr_en && (sel == SEL_FLAG);
   assign wr_ctrl = wr_en && (sel == SEL_CTRL);

   // plain bits take the written value; the update bit only sets on an event
   // or clears on a written zero, and the event wins
   always_comb begin
      flag_nxt          = wr_flag ? wdata : flag_q;
      flag_nxt[UPD_BIT] = ev | (flag_q[UPD_BIT] & ~(wr_flag & ~wdata[UPD_BIT]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q  <= '0;
         flag_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_ext)  ext_q  <= wdata;
         if (wr_ctrl) ctrl_q <= wdata;
         flag_q <= flag_nxt;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_EXT:  rdata = ext_q;
         SEL_FLAG: rdata = flag_q;
         SEL_CTRL: rdata = ctrl_q;
         default:  rdata = '0;
      endcase
   end

   assign sel_min  = ext_q[UPD_BIT];
   assign upd_flag = flag_q[UPD_BIT];
   assign upd_en   = ctrl_q[UPD_BIT];
   assign hold     = ctrl_q[HOLD_BIT];
   assign cancel   = wr_ctrl & ~wdata[UPD_BIT];
endmodule

// File: rtl/rtc_upd_evsel.sv
module rtc_upd_evsel #(
   parameter bit MIN_NEEDS_SEC = 1'b1
) (
   input  logic sec_tick,
   input  logic min_tick,
   input  logic sel_min,
   input  logic hold,
   output logic ev
);
   logic min_ev;

   generate
      if (MIN_NEEDS_SEC) begin : g_aligned
         assign min_ev = min_tick & sec_tick;
      end else begin : g_free
         assign min_ev = min_tick;
      end
   endgenerate

   assign ev = ~hold & (sel_min ? min_ev : sec_tick);
endmodule

// File: rtl/rtc_upd_release.sv
module rtc_upd_release #(
   parameter int RELEASE_TICKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ev,
   input  logic en,
   input  logic cancel,
   output logic irq
);
   localparam int CNT_W = (RELEASE_TICKS > 2) ? $clog2(RELEASE_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq   <= 1'b0;
         cnt_q <= '0;
      end else if (cancel) begin
         irq   <= 1'b0;
         cnt_q <= '0;
      end else if (ev && en) begin
         irq   <= 1'b1;
         cnt_q <= '0;
      end else if (irq && tick) begin
         if (cnt_q == LAST) begin
            irq   <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_upd_irq.sv
module rtc_upd_irq
   import rtc_upd_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 8,
   parameter int RELEASE_TICKS = 256,
   parameter bit MIN_NEEDS_SEC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              sec_tick,
   input  logic              min_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_drive_low
);
   generate
      if (DATA_W < UPD_BIT + 1) begin : g_bad_data
         $error("DATA_W too narrow for the update bit");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W cannot reach the register addresses");
      end
      if (RELEASE_TICKS < 2) begin : g_bad_ticks
         $error("RELEASE_TICKS must be at least 2");
      end
   endgenerate

   logic sel_min, upd_flag, upd_en, hold, cancel, ev;

   rtc_upd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .ev       (ev),
      .rdata    (rdata),
      .sel_min  (sel_min),
      .upd_flag (upd_flag),
      .upd_en   (upd_en),
      .hold     (hold),
      .cancel   (cancel)
   );

   rtc_upd_evsel #(.MIN_NEEDS_SEC(MIN_NEEDS_SEC)) u_evsel (
      .sec_tick (sec_tick),
      .min_tick (min_tick),
      .sel_min  (sel_min),
      .hold     (hold),
      .ev       (ev)
   );

   rtc_upd_release #(.RELEASE_TICKS(RELEASE_TICKS)) u_rel (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_32k),
      .ev     (ev),
      .en     (upd_en),
      .cancel (cancel),
      .irq    (irq_drive_low)
   );
endmodule

// File: rtl/rtc_upd_irq_chk.sv
module rtc_upd_irq_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_32k,
   input logic              sec_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq_drive_low,
   input logic              upd_flag,
   input logic              upd_en,
   input logic              hold
);
   logic flag_wr, ctrl_wr;
   assign flag_wr = wr_en && (addr == ADDR_W'(14));
   assign ctrl_wr = wr_en && (addr == ADDR_W'(15));

   a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      upd_flag && !flag_wr |=> upd_flag);

   a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      upd_flag && flag_wr && wdata[5] |=> upd_flag);

   a_r6_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_drive_low && !upd_en |=> !irq_drive_low);

   a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !wdata[5] |=> !irq_drive_low);

   a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !upd_flag |=> !upd_flag);

   a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_drive_low) |-> $past(tick_32k) || $past(ctrl_wr && !wdata[5]));

   a_r2_rise_needs_sec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_drive_low) |-> $past(sec_tick));
endmodule

bind rtc_upd_irq rtc_upd_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_32k      (tick_32k),
   .sec_tick      (sec_tick),
   .wr_en         (wr_en),
   .addr          (addr),
   .wdata         (wdata),
   .irq_drive_low (irq_drive_low),
   .upd_flag      (upd_flag),
   .upd_en        (upd_en),
   .hold          (hold)
);

// File: tb/tb_rtc_upd_irq.sv
module tb_rtc_upd_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0, sec_tick = 1'b0, min_tick = 1'b0, wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_drive_low;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      string      req;
      bit         is_rd;
      logic [7:0] exp;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   rtc_upd_irq dut (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_tick(sec_tick),
      .min_tick(min_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_drive_low(irq_drive_low)
   );

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it  = sb.pop_front();
         act = it.is_rd ? rdata : {7'd0, irq_drive_low};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic s, input logic m);
      sec_tick = s; min_tick = m;
      cyc();
      sec_tick = 1'b0; min_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_32k = 1'b1; cyc();
         tick_32k = 1'b0; cyc(); cyc();
      end
   endtask

   task automatic exp_irq(input string req, input logic v);
      item_t it;
      it.req = req; it.is_rd = 1'b0; it.exp = {7'd0, v};
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic exp_rd(input string req, input logic [3:0] a, input logic [7:0] v);
      item_t it;
      addr = a;
      it.req = req; it.is_rd = 1'b1; it.exp = v;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      exp_irq("R1 irq after reset", 1'b0);
      exp_rd("R1 ext reset", 4'hD, 8'h00);
      exp_rd("R1 flag reset", 4'hE, 8'h00);
      exp_rd("R1 ctrl reset", 4'hF, 8'h00);

      // R6 disabled: flag sets, no request; R3 flag set
      pulse(1'b1, 1'b0);
      exp_irq("R6 disabled no irq", 1'b0);
      exp_rd("R3 flag set by event", 4'hE, 8'h20);
      wr(4'hE, 8'h20);
      exp_rd("R4 write one keeps flag", 4'hE, 8'h20);
      wr(4'hE, 8'h00);
      exp_rd("R3 write zero clears flag", 4'hE, 8'h00);

      // R6 enabled
      wr(4'hF, 8'h20);
      pulse(1'b1, 1'b0);
      exp_irq("R6 enabled irq rises", 1'b1);
      wr(4'hE, 8'h00);
      exp_rd("R5 flag cleared", 4'hE, 8'h00);
      exp_irq("R5 irq held after flag clear", 1'b1);

      // R7 release window
      ticks(255);
      exp_irq("R7 still low-drive at 255", 1'b1);
      ticks(1);
      exp_irq("R7 released at 256", 1'b0);

      // R8 restart
      pulse(1'b1, 1'b0);
      ticks(200);
      pulse(1'b1, 1'b0);
      ticks(255);
      exp_irq("R8 restart holds at 255", 1'b1);
      ticks(1);
      exp_irq("R8 restart release at 256", 1'b0);

      // R9 cancel
      pulse(1'b1, 1'b0);
      exp_irq("R9 irq before cancel", 1'b1);
      wr(4'hF, 8'h00);
      exp_irq("R9 cancel releases", 1'b0);
      wr(4'hF, 8'h20);
      wr(4'hE, 8'h00);
      wr_en = 1'b1; addr = 4'hF; wdata = 8'h00; sec_tick = 1'b1;
      cyc();
      wr_en = 1'b0; sec_tick = 1'b0;
      exp_irq("R9 cancel beats same-cycle event", 1'b0);
      exp_rd("R9 flag still sets", 4'hE, 8'h20);
      wr(4'hF, 8'h20);
      wr(4'hE, 8'h00);

      // R2 minute select
      wr(4'hD, 8'h20);
      pulse(1'b1, 1'b0);
      exp_irq("R2 second ignored in minute mode", 1'b0);
      exp_rd("R2 flag clear in minute mode", 4'hE, 8'h00);
      pulse(1'b1, 1'b1);
      exp_irq("R2 minute event", 1'b1);
      exp_rd("R2 minute sets flag", 4'hE, 8'h20);
      wr(4'hD, 8'h00);
      wr(4'hF, 8'h00);
      wr(4'hE, 8'h00);

      // R10 hold
      wr(4'hF, 8'h21);
      pulse(1'b1, 1'b0);
      exp_irq("R10 hold no irq", 1'b0);
      exp_rd("R10 hold no flag", 4'hE, 8'h00);
      wr(4'hF, 8'h20);
      pulse(1'b1, 1'b0);
      exp_irq("R10 events resume", 1'b1);

      // R4 event beats clear in same cycle
      wr_en = 1'b1; addr = 4'hE; wdata = 8'h00; sec_tick = 1'b1;
      cyc();
      wr_en = 1'b0; sec_tick = 1'b0;
      exp_rd("R4 event beats clear", 4'hE, 8'h20);
      wr(4'hE, 8'h00);
      exp_rd("R4 cleared afterwards", 4'hE, 8'h00);

      // R11 readback
      wr(4'hD, 8'hC3);
      exp_rd("R11 ext stored", 4'hD, 8'hC3);
      wr(4'hE, 8'h5A);
      exp_rd("R11 flag plain bits", 4'hE, 8'h5A);
      wr(4'hE, 8'hFF);
      exp_rd("R11 flag bit5 not set by write", 4'hE, 8'hDF);
      exp_rd("R11 ctrl stored", 4'hF, 8'h20);
      exp_rd("R11 other address", 4'h3, 8'h00);

      cyc();
      done = 1'b1;
      finish_run();
   end
endmodule